// File: doc/BRIEF.md
# Narrow Load/Store Lane Aligner

This block sits between a 32-bit word-wide data memory and the register file of a simple processor pipeline. On a load it receives the memory word that holds the target location and the two low address bits. From that word it picks out the addressed byte or halfword. It then widens the result to the full register width, copying the sign bit upward for signed loads or filling with zeros for unsigned loads. On a store it receives the register value and places the low byte or low halfword into every lane that could be written. It also produces a byte-enable mask, so that the memory changes only the lanes the access covers.

Byte lanes are big-endian: address offset 0 is the most significant byte of the word. A request is presented on one cycle and its registered result appears on the next cycle. A halfword access at an odd address, or a word access with a nonzero offset, is flagged as misaligned. In that case no byte enable is raised, and the data outputs are forced to zero.

Top module: `lsa_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released with no request, resp_valid_o, misaligned_o, byte_en_o, load_data_o and store_data_o are all zero.
- R2: Each request with req_valid_i high produces its result, with resp_valid_o high, exactly one clock cycle later. A cycle with req_valid_i low produces, on the next cycle, resp_valid_o low and every other output zero.
- R3: A signed byte load (is_store_i=0, size_i=2'b00, unsigned_i=0) returns the byte at offset addr_lo_i, sign-extended to 32 bits. Offsets 0, 1, 2 and 3 select mem_rdata_i bits 31..24, 23..16, 15..8 and 7..0 respectively.
- R4: An unsigned byte load (size_i=2'b00, unsigned_i=1) returns the same byte with bits 31..8 cleared.
- R5: A halfword load (size_i=2'b01) selects bits 31..16 when addr_lo_i=0 and bits 15..0 when addr_lo_i=2. It sign-extends the halfword when unsigned_i=0 and zero-extends it when unsigned_i=1.
- R6: A word access (size_i=2'b10 or 2'b11) at offset 0 returns mem_rdata_i unchanged on a load. On a store it drives reg_wdata_i unchanged on store_data_o, with byte_en_o=4'b1111.
- R7: A byte store copies reg_wdata_i[7:0] into all four lanes of store_data_o. It sets exactly one byte_en_o bit: bit 3 for offset 0, down to bit 0 for offset 3 (byte_en_o bit i covers data bits 8i+7..8i).
- R8: A halfword store copies reg_wdata_i[15:0] into both halves of store_data_o. It sets byte_en_o=4'b1100 at offset 0 and 4'b0011 at offset 2.
- R9: A halfword access with addr_lo_i[0]=1, or a word access with addr_lo_i nonzero, sets misaligned_o. It also forces byte_en_o, load_data_o and store_data_o to zero. Byte accesses are never misaligned.
- R10: A load never raises any byte_en_o bit and leaves store_data_o zero. A store leaves load_data_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A request is present this cycle |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| size_i | input | 2 | 00 byte, 01 halfword, 10/11 word |
| unsigned_i | input | 1 | Zero-extend narrow loads when set |
| addr_lo_i | input | 2 | Byte offset within the word |
| mem_rdata_i | input | 32 | Word read from memory (loads) |
| reg_wdata_i | input | 32 | Register value to store |
| resp_valid_o | output | 1 | Registered result is valid |
| load_data_o | output | 32 | Extended load result |
| store_data_o | output | 32 | Lane-replicated write data |
| byte_en_o | output | 4 | Write byte-enable mask |
| misaligned_o | output | 1 | Access offset illegal for its size |

## Verification
The only state in the block is the single result register, so any fault in the lane selection or masking shows up at the ports one cycle after the request that caused it. A lane reversal shows as the wrong byte in load_data_o or a mirrored byte_en_o pattern. A fault in the sign fill shows in the upper bits of the load result. Stale state leaking across cycles shows as nonzero outputs on the idle cycle that follows a request.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic              valid;
        logic              mis;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] ld;
        logic [DATA_W-1:0] st;
    } resp_t;
endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
    import lsa_pkg::*;
#(
    parameter int unsigned OW = OFF_W
) (
    input  acc_size_e     size_i,
    input  logic [OW-1:0] off_i,
    output logic          mis_o
);
    always_comb begin
        unique case (size_i)
            SZ_BYTE: mis_o = 1'b0;
            SZ_HALF: mis_o = off_i[0];
            default: mis_o = |off_i;
        endcase
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic [DW-1:0]            word_i,
    input  logic [$clog2(DW/8)-1:0]  off_i,
    input  acc_size_e                size_i,
    input  logic                     uns_i,
    output logic [DW-1:0]            data_o
);
    localparam int unsigned NL = DW / 8;
    localparam int unsigned OW = $clog2(NL);
    localparam int unsigned NH = NL / 2;

    logic [OW-1:0] byte_lane;
    logic [OW-2:0] half_lane;
    logic [7:0]    byte_sel;
    logic [15:0]   half_sel;

    always_comb begin
        // big-endian: offset 0 is the top lane
        byte_lane = OW'(NL - 1) - off_i;
        half_lane = (OW-1)'(NH - 1) - off_i[OW-1:1];
        byte_sel  = word_i[{byte_lane, 3'b000} +: 8];
        half_sel  = word_i[{half_lane, 4'b0000} +: 16];
        unique case (size_i)
            SZ_BYTE: data_o = {{(DW-8){byte_sel[7] & ~uns_i}}, byte_sel};
            SZ_HALF: data_o = {{(DW-16){half_sel[15] & ~uns_i}}, half_sel};
            default: data_o = word_i;
        endcase
    end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
    import lsa_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic [DW-1:0]            src_i,
    input  logic [$clog2(DW/8)-1:0]  off_i,
    input  acc_size_e                size_i,
    output logic [DW-1:0]            data_o,
    output logic [DW/8-1:0]          be_o
);
    localparam int unsigned NL = DW / 8;
    localparam int unsigned OW = $clog2(NL);
    localparam int unsigned NH = NL / 2;

    logic [OW-1:0] byte_lane;
    logic [OW-2:0] half_lane;
    logic [DW-1:0] byte_rep;
    logic [DW-1:0] half_rep;

    for (genvar l = 0; l < NL; l++) begin : g_byte_rep
        assign byte_rep[8*l +: 8] = src_i[7:0];
    end
    for (genvar h = 0; h < NH; h++) begin : g_half_rep
        assign half_rep[16*h +: 16] = src_i[15:0];
    end

    always_comb begin
        byte_lane = OW'(NL - 1) - off_i;
        half_lane = (OW-1)'(NH - 1) - off_i[OW-1:1];
        unique case (size_i)
            SZ_BYTE: begin
                data_o = byte_rep;
                be_o   = NL'(1) << byte_lane;
            end
            SZ_HALF: begin
                data_o = half_rep;
                be_o   = NL'(3) << {half_lane, 1'b0};
            end
            default: begin
                data_o = src_i;
                be_o   = '1;
            end
        endcase
    end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
    import lsa_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        req_valid_i,
    input  logic        is_store_i,
    input  logic [1:0]  size_i,
    input  logic        unsigned_i,
    input  logic [1:0]  addr_lo_i,
    input  logic [31:0] mem_rdata_i,
    input  logic [31:0] reg_wdata_i,
    output logic        resp_valid_o,
    output logic [31:0] load_data_o,
    output logic [31:0] store_data_o,
    output logic [3:0]  byte_en_o,
    output logic        misaligned_o
);
    acc_size_e         size_w;
    logic              mis_w;
    logic [DATA_W-1:0] ld_w;
    logic [DATA_W-1:0] st_w;
    logic [LANES-1:0]  be_w;
    resp_t             resp_d, resp_q;

    assign size_w = acc_size_e'(size_i);

    lsa_align_check #(.OW(OFF_W)) chk_i (
        .size_i (size_w),
        .off_i  (addr_lo_i),
        .mis_o  (mis_w)
    );

    lsa_load_extract #(.DW(DATA_W)) ld_i (
        .word_i (mem_rdata_i),
        .off_i  (addr_lo_i),
        .size_i (size_w),
        .uns_i  (unsigned_i),
        .data_o (ld_w)
    );

    lsa_store_lanes #(.DW(DATA_W)) st_i (
        .src_i  (reg_wdata_i),
        .off_i  (addr_lo_i),
        .size_i (size_w),
        .data_o (st_w),
        .be_o   (be_w)
    );

    always_comb begin
        resp_d = '0;
        if (req_valid_i) begin
            resp_d.valid = 1'b1;
            resp_d.mis   = mis_w;
            if (!mis_w) begin
                if (is_store_i) begin
                    resp_d.st = st_w;
                    resp_d.be = be_w;
                end else begin
                    resp_d.ld = ld_w;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) resp_q <= '0;
        else         resp_q <= resp_d;
    end

    assign resp_valid_o = resp_q.valid;
    assign misaligned_o = resp_q.mis;
    assign byte_en_o    = resp_q.be;
    assign load_data_o  = resp_q.ld;
    assign store_data_o = resp_q.st;

    assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (!resp_valid_o && byte_en_o == '0 && !misaligned_o));

    assert_lbu_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !is_store_i && size_i == 2'b00 && unsigned_i)
            |=> load_data_o[31:8] == '0);

    assert_sb_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && is_store_i && size_i == 2'b00) |=> $onehot(byte_en_o));

    assert_sh_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && is_store_i && size_i == 2'b01 && !addr_lo_i[0])
            |=> $countones(byte_en_o) == 2);

    assert_mis_noen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        misaligned_o |-> (byte_en_o == '0 && load_data_o == '0));

    assert_load_noen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !is_store_i) |=> (byte_en_o == '0 && store_data_o == '0));
endmodule

// File: tb/lsa_unit_tb.sv
module lsa_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        is_store = 1'b0;
    logic [1:0]  size = 2'b00;
    logic        uns = 1'b0;
    logic [1:0]  addr = 2'b00;
    logic [31:0] mem_rd = '0;
    logic [31:0] reg_wd = '0;
    logic        resp_valid;
    logic [31:0] load_data;
    logic [31:0] store_data;
    logic [3:0]  byte_en;
    logic        misaligned;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    lsa_unit dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_valid_i  (req_valid),
        .is_store_i   (is_store),
        .size_i       (size),
        .unsigned_i   (uns),
        .addr_lo_i    (addr),
        .mem_rdata_i  (mem_rd),
        .reg_wdata_i  (reg_wd),
        .resp_valid_o (resp_valid),
        .load_data_o  (load_data),
        .store_data_o (store_data),
        .byte_en_o    (byte_en),
        .misaligned_o (misaligned)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, result registered at posedge, sample at next negedge
    task automatic issue(input logic st, input logic [1:0] sz, input logic u,
                         input logic [1:0] a, input logic [31:0] m, input logic [31:0] r);
        req_valid = 1'b1; is_store = st; size = sz; uns = u;
        addr = a; mem_rd = m; reg_wd = r;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_all(input string req, input logic [31:0] ld, input logic [31:0] sd,
                              input logic [3:0] be, input logic mis);
        check({req, " valid"}, {31'd0, resp_valid}, 32'd1);
        check({req, " load"},  load_data, ld);
        check({req, " store"}, store_data, sd);
        check({req, " be"},    {28'd0, byte_en}, {28'd0, be});
        check({req, " mis"},   {31'd0, misaligned}, {31'd0, mis});
    endtask

    task automatic t_reset();
        check("R1 valid", {31'd0, resp_valid}, 32'd0);
        check("R1 load",  load_data, 32'd0);
        check("R1 store", store_data, 32'd0);
        check("R1 be",    {28'd0, byte_en}, 32'd0);
        check("R1 mis",   {31'd0, misaligned}, 32'd0);
    endtask

    task automatic t_lb();
        logic [31:0] w = 32'h8A7F_C301;
        logic [31:0] exp_v [4] = '{32'hFFFF_FF8A, 32'h0000_007F, 32'hFFFF_FFC3, 32'h0000_0001};
        for (int k = 0; k < 4; k++) begin
            issue(1'b0, 2'b00, 1'b0, 2'(k), w, 32'hDEAD_BEEF);
            expect_all("R3 lb", exp_v[k], 32'd0, 4'b0000, 1'b0);
        end
    endtask

    task automatic t_lbu();
        issue(1'b0, 2'b00, 1'b1, 2'd0, 32'h8A7F_C301, '0);
        expect_all("R4 lbu0", 32'h0000_008A, 32'd0, 4'b0000, 1'b0);
        issue(1'b0, 2'b00, 1'b1, 2'd2, 32'h8A7F_C301, '0);
        expect_all("R4 lbu2", 32'h0000_00C3, 32'd0, 4'b0000, 1'b0);
    endtask

    task automatic t_half_load();
        issue(1'b0, 2'b01, 1'b0, 2'd0, 32'h8A7F_C301, '0);
        expect_all("R5 lh0", 32'hFFFF_8A7F, 32'd0, 4'b0000, 1'b0);
        issue(1'b0, 2'b01, 1'b0, 2'd2, 32'h8A7F_C301, '0);
        expect_all("R5 lh2", 32'hFFFF_C301, 32'd0, 4'b0000, 1'b0);
        issue(1'b0, 2'b01, 1'b0, 2'd2, 32'h12F0_7F80, '0);
        expect_all("R5 lh2pos", 32'h0000_7F80, 32'd0, 4'b0000, 1'b0);
        issue(1'b0, 2'b01, 1'b1, 2'd0, 32'h8A7F_C301, '0);
        expect_all("R5 lhu0", 32'h0000_8A7F, 32'd0, 4'b0000, 1'b0);
    endtask

    task automatic t_word();
        issue(1'b0, 2'b10, 1'b0, 2'd0, 32'h8A7F_C301, 32'h5555_5555);
        expect_all("R6 lw", 32'h8A7F_C301, 32'd0, 4'b0000, 1'b0);
        issue(1'b1, 2'b10, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'hCAFE_1234);
        expect_all("R6 sw", 32'd0, 32'hCAFE_1234, 4'b1111, 1'b0);
        issue(1'b1, 2'b11, 1'b0, 2'd0, 32'h0, 32'h0BAD_F00D);
        expect_all("R6 sw11", 32'd0, 32'h0BAD_F00D, 4'b1111, 1'b0);
    endtask

    task automatic t_sb();
        for (int k = 0; k < 4; k++) begin
            issue(1'b1, 2'b00, 1'b0, 2'(k), 32'h1111_1111, 32'h1234_565A);
            expect_all("R7 sb", 32'd0, 32'h5A5A_5A5A, 4'(4'b1000 >> k), 1'b0);
        end
    endtask

    task automatic t_sh();
        issue(1'b1, 2'b01, 1'b0, 2'd0, '0, 32'h7777_BEEF);
        expect_all("R8 sh0", 32'd0, 32'hBEEF_BEEF, 4'b1100, 1'b0);
        issue(1'b1, 2'b01, 1'b0, 2'd2, '0, 32'h7777_BEEF);
        expect_all("R8 sh2", 32'd0, 32'hBEEF_BEEF, 4'b0011, 1'b0);
    endtask

    task automatic t_misaligned();
        issue(1'b0, 2'b01, 1'b0, 2'd1, 32'h8A7F_C301, '0);
        expect_all("R9 lh1", 32'd0, 32'd0, 4'b0000, 1'b1);
        issue(1'b1, 2'b01, 1'b0, 2'd3, '0, 32'h7777_BEEF);
        expect_all("R9 sh3", 32'd0, 32'd0, 4'b0000, 1'b1);
        issue(1'b0, 2'b10, 1'b0, 2'd2, 32'h8A7F_C301, '0);
        expect_all("R9 lw2", 32'd0, 32'd0, 4'b0000, 1'b1);
        issue(1'b1, 2'b10, 1'b0, 2'd1, '0, 32'hCAFE_1234);
        expect_all("R9 sw1", 32'd0, 32'd0, 4'b0000, 1'b1);
        issue(1'b1, 2'b00, 1'b0, 2'd3, '0, 32'h0000_00A5);
        expect_all("R9 sb3ok", 32'd0, 32'hA5A5_A5A5, 4'b0001, 1'b0);
    endtask

    task automatic t_idle_and_cross();
        // load with store data present: R10
        issue(1'b0, 2'b00, 1'b0, 2'd1, 32'h00FF_0000, 32'hFFFF_FFFF);
        expect_all("R10 ld", 32'hFFFF_FFFF, 32'd0, 4'b0000, 1'b0);
        // store with memory data present: R10
        issue(1'b1, 2'b01, 1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0000_1357);
        expect_all("R10 st", 32'd0, 32'h1357_1357, 4'b1100, 1'b0);
        // idle cycle: R2
        @(posedge clk);
        @(negedge clk);
        check("R2 idle valid", {31'd0, resp_valid}, 32'd0);
        check("R2 idle load",  load_data, 32'd0);
        check("R2 idle store", store_data, 32'd0);
        check("R2 idle be",    {28'd0, byte_en}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        t_reset();
        t_lb();
        t_lbu();
        t_half_load();
        t_word();
        t_sb();
        t_sh();
        t_misaligned();
        t_idle_and_cross();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule